// File: doc/BRIEF.md
# Sliding-Window Score Fault Monitor

This block sits beside a hyperdimensional classifier and watches the similarity scores that the classifier produces for every inference. The class scores arrive one per beat on a streamed bus. The block tracks the smallest score and the running total of the scores. The winning score comes from an external argmax unit and is taken with the final beat. From these values the block derives one margin metric per inference.

The recent metrics are kept in a circular history of power-of-two depth. The block keeps a running sum of that history, so the window average is a right shift. The average is read from the stored history before the new metric goes in. If a new metric falls below that average by more than a programmable threshold, the block raises a sticky error flag. A healthy classifier keeps a steady margin, while a classifier damaged by accumulating hardware faults loses margin suddenly. The flag stays set until software pulses a clear input. No comparison is made until the history has filled once after reset.

Top module: `score_drift_monitor`

## Requirements
- R1: After reset `err_flag` is low and the history holds no metrics.
- R2: An inference is the run of beats with `score_valid` high, ending with the beat that has `score_last` high. The minimum and the sum are taken over those beats only, whatever order the scores come in. Cycles with `score_valid` low have no effect, even if `score_data` holds a smaller value then.
- R3: The winning score is the value on `winner_score` during the last beat. The score stream is not searched for a maximum.
- R4: With `metric_sel` = 0, the metric is `winner_score` minus the minimum, clamped to 0 if negative.
- R5: With `metric_sel` = 1, the metric is `winner_score` × NUM_CLASSES minus the sum of the scores, clamped to 0 if negative.
- R6: The window average is floor(sum of the WINDOW_DEPTH stored metrics / WINDOW_DEPTH). It is taken before the new metric is stored. A drift hit occurs when the average is greater than the new metric plus `drift_threshold`. Equality is not a hit.
- R7: No drift hit occurs while fewer than WINDOW_DEPTH metrics have been stored since reset.
- R8: On a drift hit, `err_flag` goes high at the first rising edge after the edge that samples the last beat. It then stays high for as long as it is not cleared.
- R9: `err_clear` high at a rising edge drops `err_flag`, unless a drift hit is being registered at that same edge.
- R10: Once the history is full, each new metric replaces the oldest one. The average therefore always covers the most recent WINDOW_DEPTH metrics, across any number of pointer wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| score_valid | input | 1 | A class score is present on `score_data` |
| score_data | input | SCORE_W | One class similarity score (unsigned) |
| score_last | input | 1 | Marks the final score of an inference |
| winner_score | input | SCORE_W | Score of the winning class from the argmax, valid with the last beat |
| metric_sel | input | 1 | 0: winner minus minimum, 1: winner×classes minus sum |
| drift_threshold | input | SCORE_W | Allowed drop of a metric below the window average |
| err_clear | input | 1 | Clears the sticky error flag |
| err_flag | output | 1 | Sticky fault indication |

## Verification
The bench fills the history with a steady margin and then lowers the margin step by step. It lands once exactly on the boundary where the average equals the metric plus the threshold, and then one count past it. An off-by-one in the comparison would flag one inference early or one late. A second case puts a zero-margin inference into the last slot before the history is full. A design that compared too early would flag there. A long run with varied margins walks the pointers around the history several times. A design that subtracted the wrong entry, or that never subtracted an entry, would let its average drift away from the bench's model and flag at the wrong inferences. Further cases check the following:
- Idle cycles carry small values on the data bus that must not count toward the minimum.
- The winner value sent on `winner_score` differs from the largest value in the stream, so a design that recomputed the maximum would get a different metric.
- The total-margin metric mode is exercised.

// File: rtl/sdm_pkg.sv
package sdm_pkg;

  // Selects how the per-inference margin metric is formed.
  typedef enum logic {
    METRIC_SPAN  = 1'b0,  // winner minus minimum
    METRIC_TOTAL = 1'b1   // winner times class count minus score sum
  } metric_kind_e;

endpackage

// File: rtl/sdm_score_scan.sv
// Sequential scan of one inference's class scores: minimum and sum,
// one beat per clock, plus capture of the external winner score.
module sdm_score_scan #(
  parameter int SCORE_W = 16,
  parameter int SUM_W   = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               beat_valid,
  input  logic [SCORE_W-1:0] beat_data,
  input  logic               beat_last,
  input  logic [SCORE_W-1:0] win_score,
  output logic               frame_done,
  output logic [SCORE_W-1:0] frame_min,
  output logic [SCORE_W-1:0] frame_max,
  output logic [SUM_W-1:0]   frame_sum
);

  function automatic logic [SCORE_W-1:0] lower_of(input logic [SCORE_W-1:0] a,
                                                  input logic [SCORE_W-1:0] b);
    return (a < b) ? a : b;
  endfunction

  logic               first_q;
  logic               done_q;
  logic [SCORE_W-1:0] min_q;
  logic [SCORE_W-1:0] max_q;
  logic [SUM_W-1:0]   sum_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= 1'b1;
      done_q  <= 1'b0;
      min_q   <= '0;
      max_q   <= '0;
      sum_q   <= '0;
    end else begin
      done_q <= beat_valid && beat_last;
      if (beat_valid) begin
        if (first_q) begin
          min_q <= beat_data;
          sum_q <= SUM_W'(beat_data);
        end else begin
          min_q <= lower_of(min_q, beat_data);
          sum_q <= sum_q + SUM_W'(beat_data);
        end
        first_q <= beat_last;
        if (beat_last) max_q <= win_score;
      end
    end
  end

  assign frame_done = done_q;
  assign frame_min  = min_q;
  assign frame_max  = max_q;
  assign frame_sum  = sum_q;

endmodule

// File: rtl/sdm_metric.sv
// Combinational per-inference margin metric.
module sdm_metric
  import sdm_pkg::*;
#(
  parameter int SCORE_W     = 16,
  parameter int SUM_W       = 20,
  parameter int NUM_CLASSES = 10
) (
  input  metric_kind_e       kind,
  input  logic [SCORE_W-1:0] fmax,
  input  logic [SCORE_W-1:0] fmin,
  input  logic [SUM_W-1:0]   fsum,
  output logic [SUM_W-1:0]   metric
);

  function automatic logic [SUM_W-1:0] span_margin(input logic [SCORE_W-1:0] hi,
                                                   input logic [SCORE_W-1:0] lo);
    return (hi > lo) ? SUM_W'(hi - lo) : '0;
  endfunction

  function automatic logic [SUM_W-1:0] total_margin(input logic [SCORE_W-1:0] hi,
                                                    input logic [SUM_W-1:0]   tot);
    logic [SUM_W-1:0] scaled;
    scaled = SUM_W'(hi) * SUM_W'(NUM_CLASSES);
    return (scaled > tot) ? (scaled - tot) : '0;
  endfunction

  always_comb begin
    if (kind == METRIC_TOTAL) metric = total_margin(fmax, fsum);
    else                      metric = span_margin(fmax, fmin);
  end

endmodule

// File: rtl/sdm_history.sv
// Circular history of metrics with an incrementally kept window sum.
// DEPTH must be a power of two: the average is a shift and the
// pointers wrap by overflow.
module sdm_history #(
  parameter int METRIC_W = 20,
  parameter int THR_W    = 16,
  parameter int DEPTH    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                push,
  input  logic [METRIC_W-1:0] metric,
  input  logic [THR_W-1:0]    threshold,
  output logic                hit
);

  localparam int DEPTH_LG = $clog2(DEPTH);
  localparam int CNT_W    = DEPTH_LG + 1;
  localparam int WSUM_W   = METRIC_W + DEPTH_LG;

  function automatic logic [METRIC_W-1:0] window_mean(input logic [WSUM_W-1:0] s);
    return METRIC_W'(s >> DEPTH_LG);
  endfunction

  function automatic logic falls_short(input logic [METRIC_W-1:0] mean,
                                       input logic [METRIC_W-1:0] m,
                                       input logic [THR_W-1:0]    thr);
    return {1'b0, mean} > ({1'b0, m} + (METRIC_W+1)'(thr));
  endfunction

  logic [METRIC_W-1:0] mem_q [DEPTH];
  logic [DEPTH_LG-1:0] wr_ptr_q;   // newest-entry pointer (next write)
  logic [DEPTH_LG-1:0] rd_ptr_q;   // oldest-entry pointer
  logic [CNT_W-1:0]    fill_q;
  logic [WSUM_W-1:0]   wsum_q;
  logic                full;
  logic [WSUM_W-1:0]   leaving;

  assign full    = (fill_q == CNT_W'(DEPTH));
  assign leaving = full ? WSUM_W'(mem_q[rd_ptr_q]) : '0;
  assign hit     = push && full && falls_short(window_mean(wsum_q), metric, threshold);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      fill_q   <= '0;
      wsum_q   <= '0;
    end else if (push) begin
      mem_q[wr_ptr_q] <= metric;
      wr_ptr_q        <= wr_ptr_q + 1'b1;
      wsum_q          <= wsum_q + WSUM_W'(metric) - leaving;
      if (full) rd_ptr_q <= rd_ptr_q + 1'b1;
      else      fill_q   <= fill_q + 1'b1;
    end
  end

endmodule

// File: rtl/score_drift_monitor.sv
module score_drift_monitor
  import sdm_pkg::*;
#(
  parameter int SCORE_W      = 16,
  parameter int NUM_CLASSES  = 10,
  parameter int WINDOW_DEPTH = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               score_valid,
  input  logic [SCORE_W-1:0] score_data,
  input  logic               score_last,
  input  logic [SCORE_W-1:0] winner_score,
  input  logic               metric_sel,
  input  logic [SCORE_W-1:0] drift_threshold,
  input  logic               err_clear,
  output logic               err_flag
);

  localparam int SUM_W = SCORE_W + $clog2(NUM_CLASSES + 1);

  logic               frame_done;
  logic [SCORE_W-1:0] frame_min;
  logic [SCORE_W-1:0] frame_max;
  logic [SUM_W-1:0]   frame_sum;
  logic [SUM_W-1:0]   frame_metric;
  logic               drift_hit;
  logic               err_q;
  metric_kind_e       kind;

  assign kind = metric_kind_e'(metric_sel);

  sdm_score_scan #(
    .SCORE_W (SCORE_W),
    .SUM_W   (SUM_W)
  ) scan_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .beat_valid (score_valid),
    .beat_data  (score_data),
    .beat_last  (score_last),
    .win_score  (winner_score),
    .frame_done (frame_done),
    .frame_min  (frame_min),
    .frame_max  (frame_max),
    .frame_sum  (frame_sum)
  );

  sdm_metric #(
    .SCORE_W     (SCORE_W),
    .SUM_W       (SUM_W),
    .NUM_CLASSES (NUM_CLASSES)
  ) metric_i (
    .kind   (kind),
    .fmax   (frame_max),
    .fmin   (frame_min),
    .fsum   (frame_sum),
    .metric (frame_metric)
  );

  sdm_history #(
    .METRIC_W (SUM_W),
    .THR_W    (SCORE_W),
    .DEPTH    (WINDOW_DEPTH)
  ) hist_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (frame_done),
    .metric    (frame_metric),
    .threshold (drift_threshold),
    .hit       (drift_hit)
  );

  // A new hit wins over a clear in the same cycle so no event is lost.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         err_q <= 1'b0;
    else if (drift_hit) err_q <= 1'b1;
    else if (err_clear) err_q <= 1'b0;
  end

  assign err_flag = err_q;

endmodule

// File: rtl/sdm_checker.sv
module sdm_checker #(
  parameter int SCORE_W = 16,
  parameter int SUM_W   = 20
) (
  input logic               clk,
  input logic               rst_n,
  input logic               metric_sel,
  input logic               err_clear,
  input logic               err_flag,
  input logic               frame_done,
  input logic [SCORE_W-1:0] frame_min,
  input logic [SCORE_W-1:0] frame_max,
  input logic [SUM_W-1:0]   frame_sum,
  input logic [SUM_W-1:0]   frame_metric,
  input logic               drift_hit
);

  assert_sum_covers_min_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> frame_sum >= SUM_W'(frame_min));

  assert_span_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !metric_sel) |-> frame_metric <= SUM_W'(frame_max));

  assert_flag_has_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> $past(drift_hit));

  assert_hit_only_on_push_R7: assert property (@(posedge clk) disable iff (!rst_n)
    drift_hit |-> frame_done);

  assert_hit_sets_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    drift_hit |=> err_flag);

  assert_flag_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !err_clear) |=> err_flag);

  assert_clear_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clear && !drift_hit) |=> !err_flag);

endmodule

bind score_drift_monitor sdm_checker #(
  .SCORE_W (SCORE_W),
  .SUM_W   (SUM_W)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .metric_sel   (metric_sel),
  .err_clear    (err_clear),
  .err_flag     (err_flag),
  .frame_done   (frame_done),
  .frame_min    (frame_min),
  .frame_max    (frame_max),
  .frame_sum    (frame_sum),
  .frame_metric (frame_metric),
  .drift_hit    (drift_hit)
);

// File: tb/score_drift_monitor_tb_top.sv
`timescale 1ns/1ps
module score_drift_monitor_tb_top;

  localparam int SW = 16;
  localparam int NC = 10;
  localparam int WD = 16;
  localparam int ROWS = 20;

  // Table: winner score, minimum, filler score, expected flag (threshold 8, span mode).
  localparam int TBL_MAX [ROWS] = '{300,300,300,300,300,300,300,300,300,300,
                                    300,300,300,300,300,300,300,295,291,290};
  localparam int TBL_MIN [ROWS] = '{200,200,200,200,200,200,200,200,200,200,
                                    200,200,200,200,200,200,200,200,200,200};
  localparam int TBL_MID [ROWS] = '{250,250,250,250,250,250,250,250,250,250,
                                    250,250,250,250,250,250,250,250,250,250};
  localparam int TBL_EXP [ROWS] = '{0,0,0,0,0,0,0,0,0,0,
                                    0,0,0,0,0,0,0,0,0,1};

  logic          clk = 1'b0;
  logic          rst_n;
  logic          score_valid;
  logic [SW-1:0] score_data;
  logic          score_last;
  logic [SW-1:0] winner_score;
  logic          metric_sel;
  logic [SW-1:0] drift_threshold;
  logic          err_clear;
  logic          err_flag;

  int n_checks = 0;
  int n_errs   = 0;
  bit finished = 1'b0;

  // Bench model of the history window.
  int m_hist [WD];
  int m_cnt, m_sum, m_wr;
  bit m_flag;

  always #2.5 clk = ~clk;

  score_drift_monitor #(
    .SCORE_W      (SW),
    .NUM_CLASSES  (NC),
    .WINDOW_DEPTH (WD)
  ) dut_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .score_valid     (score_valid),
    .score_data      (score_data),
    .score_last      (score_last),
    .winner_score    (winner_score),
    .metric_sel      (metric_sel),
    .drift_threshold (drift_threshold),
    .err_clear       (err_clear),
    .err_flag        (err_flag)
  );

  task automatic check_eq(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errs++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < WD; i++) m_hist[i] = 0;
    m_cnt = 0; m_sum = 0; m_wr = 0; m_flag = 1'b0;
  endtask

  task automatic model_push(input int metric);
    int avg;
    avg = m_sum / WD;
    if (m_cnt == WD && avg > metric + int'(drift_threshold)) m_flag = 1'b1;
    if (m_cnt == WD) m_sum = m_sum - m_hist[m_wr];
    else             m_cnt++;
    m_hist[m_wr] = metric;
    m_sum = m_sum + metric;
    m_wr = (m_wr + 1) % WD;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; score_valid = 1'b0; score_last = 1'b0; score_data = '0;
    winner_score = '0; err_clear = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    @(negedge clk);
  endtask

  // One inference; the winner slot in the stream carries stream_max,
  // the port carries port_max; gap idle cycles with junk data sit between beats.
  task automatic run_inf(input int port_max, input int stream_max, input int mn,
                         input int mid, input int minpos, input int gap);
    int maxpos, sum, metric;
    maxpos = (minpos + 3) % NC;
    sum = 0;
    for (int k = 0; k < NC; k++) begin
      int v;
      v = (k == minpos) ? mn : ((k == maxpos) ? stream_max : mid);
      sum += v;
      for (int g = 0; g < gap; g++) begin
        score_valid = 1'b0; score_last = 1'b0; score_data = SW'(1);
        @(negedge clk);
      end
      score_valid  = 1'b1;
      score_data   = SW'(v);
      score_last   = (k == NC - 1);
      winner_score = (k == NC - 1) ? SW'(port_max) : SW'(7);
      @(negedge clk);
    end
    score_valid = 1'b0; score_last = 1'b0; score_data = SW'(1);
    if (metric_sel) metric = (port_max * NC > sum) ? port_max * NC - sum : 0;
    else            metric = (port_max > mn) ? port_max - mn : 0;
    model_push(metric);
  endtask

  task automatic pulse_clear();
    err_clear = 1'b1;
    @(negedge clk);
    err_clear = 1'b0;
    m_flag = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      n_checks++; n_errs++;
      $display("FAIL watchdog (R1..all): actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

  initial begin
    metric_sel = 1'b0;
    drift_threshold = SW'(8);
    do_reset();
    check_eq("R1 flag low after reset", int'(err_flag), 0);

    // Table walk: stable margin, then a shrinking margin to the exact boundary.
    for (int r = 0; r < ROWS; r++) begin
      run_inf(TBL_MAX[r], TBL_MAX[r], TBL_MIN[r], TBL_MID[r], r % NC, r % 3);
      @(negedge clk);
      check_eq($sformatf("R6 table row %0d (R2 gaps, R4 span)", r), int'(err_flag), TBL_EXP[r]);
    end

    repeat (6) @(negedge clk);
    check_eq("R8 flag sticky while idle", int'(err_flag), 1);
    pulse_clear();
    check_eq("R9 clear drops flag", int'(err_flag), 0);
    run_inf(300, 300, 200, 250, 4, 0);
    @(negedge clk);
    check_eq("R9 stays low after clear with stable margin", int'(err_flag), 0);

    // R7: a collapse in the last slot before the window is full is ignored.
    do_reset();
    check_eq("R1 flag low after second reset", int'(err_flag), 0);
    for (int i = 0; i < WD - 1; i++) run_inf(400, 400, 200, 300, i % NC, 0);
    run_inf(200, 200, 200, 200, 2, 1);
    @(negedge clk);
    check_eq("R7 no hit before window fills", int'(err_flag), 0);
    run_inf(380, 380, 200, 300, 5, 0);
    @(negedge clk);
    check_eq("R6 avg 187 vs 180+8 no hit", int'(err_flag), 0);
    run_inf(370, 370, 200, 300, 8, 0);
    @(negedge clk);
    check_eq("R6 avg 186 vs 170+8 hit", int'(err_flag), 1);

    // R10: long run with varied margins, several pointer wraps.
    do_reset();
    drift_threshold = SW'(20);
    for (int i = 0; i < 56; i++) begin
      int mg;
      mg = 100 + (i * 37) % 60;
      run_inf(200 + mg, 200 + mg, 200, 210, (i * 7) % NC, i % 2);
      @(negedge clk);
      check_eq($sformatf("R10 wrap step %0d", i), int'(err_flag), int'(m_flag));
      if (err_flag || m_flag) pulse_clear();
    end

    // R3: winner taken from the port, not from the stream.
    do_reset();
    drift_threshold = SW'(8);
    for (int i = 0; i < WD; i++) run_inf(300, 250, 200, 240, i % NC, 0);
    run_inf(300, 250, 200, 240, 3, 0);
    @(negedge clk);
    check_eq("R3 port winner, steady margin 100", int'(err_flag), 0);
    run_inf(250, 250, 200, 240, 6, 0);
    @(negedge clk);
    check_eq("R3 port winner drop to 50 hits", int'(err_flag), 1);

    // R5: total-margin mode.
    metric_sel = 1'b1;
    do_reset();
    for (int i = 0; i < WD; i++) run_inf(300, 300, 200, 250, i % NC, 0);
    run_inf(300, 300, 200, 250, 1, 0);
    @(negedge clk);
    check_eq("R5 total margin 500 steady", int'(err_flag), 0);
    run_inf(210, 210, 200, 205, 7, 2);
    @(negedge clk);
    check_eq("R5 total margin collapse to 50", int'(err_flag), 1);
    check_eq("R5 model agrees on collapse", int'(m_flag), 1);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

endmodule